// File: doc/BRIEF.md
# Converter Clock Divider Selector

This block chooses how the shared analog clock of a converter group is derived. A start pulse makes it capture the rate of an optional asynchronous kernel clock and the rate of a mandatory bus clock, both given in Hz. It also captures a 32-bit common control word. It then walks a fixed table of divider settings, one entry per clock cycle, and stops at the first entry whose divided rate does not exceed `MAX_HZ`. The asynchronous entries come first. The bus-clock entries are searched only when the asynchronous clock is absent or none of its entries fit.

When the search ends, `done` is high for one cycle. The results stay on the outputs until the next search completes. These results are the 2-bit mode, the 4-bit prescaler code, the divided analog rate, a boost flag, an error flag and the control word with the two fields written in. Software or a sequencer writes the returned control word back into the common register.

The state machine has six states, each with named transitions:
- IDLE moves to PREP on `start`.
- PREP moves to DONE_ERR when the bus clock is absent, or when the clock it would scan first reports a rate of zero. Otherwise it moves to SCAN_ASYNC, or to SCAN_BUS when the asynchronous clock is absent.
- SCAN_ASYNC moves to DONE_OK when the current entry fits. After its last entry it moves to SCAN_BUS, or to DONE_ERR if the bus rate is zero. Otherwise it steps to the next entry.
- SCAN_BUS moves to DONE_OK when the current entry fits. After its last entry it moves to DONE_ERR. Otherwise it steps to the next entry.
- DONE_OK and DONE_ERR return to IDLE unconditionally.

Top module: `adc_clk_sel`

## Requirements
- R1: After reset, `done`, `error`, `mode`, `presc`, `ana_rate_hz`, `boost` and `ctrl_out` are all zero.
- R2: The asynchronous table has twelve entries with mode 0. Prescaler code k (0..11) divides by 1, 2, 4, 6, 8, 10, 12, 16, 32, 64, 128 and 256 for k = 0, 1, ..., 11. The first entry in that order whose truncated quotient rate/divisor is at most `MAX_HZ` (default 36,000,000) is chosen.
- R3: The bus table has three entries with prescaler code 0, searched in this order: mode 1 divides by 1, mode 2 divides by 2, mode 3 divides by 4. The first entry whose quotient is at most `MAX_HZ` is chosen.
- R4: When the asynchronous clock is present, its table is searched first, and the bus table only after every asynchronous entry has failed. A bus rate of zero has no effect when an asynchronous entry fits.
- R5: The search ends with `error` high in four cases:
  - the bus clock is absent;
  - the asynchronous clock is present with rate zero;
  - the bus table is reached with a bus rate of zero;
  - no entry of the searched tables fits.
- R6: On success, `ana_rate_hz` equals the chosen clock rate divided by the chosen divisor, truncated. On error it is zero, and `mode` and `presc` are zero.
- R7: On success, `boost` is high exactly when `ana_rate_hz` exceeds `BOOST_HZ` (default 20,000,000). On error it is low.
- R8: On success, `ctrl_out` is the captured `ctrl_in` with bits 17:16 replaced by the mode and bits 21:18 replaced by the prescaler code, all other bits kept. On error, `ctrl_out` equals the captured `ctrl_in`.
- R9: Counting clock edges after the edge that samples `start`, `done` rises after:
  - 1 edge for an error found in PREP;
  - 2+k edges when asynchronous entry k is chosen;
  - 13 edges for the zero-bus-rate error after the asynchronous table;
  - b+j edges when bus entry j (0..2) is chosen, where b is 14 with the asynchronous clock present and 2 without it;
  - b+2 edges when no bus entry fits.
- R10: `done` is high for exactly one cycle per search.
- R11: `start` is ignored while a search is in progress.
- R12: Rates, presence flags and `ctrl_in` are sampled at the edge that accepts `start`. Later changes do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a search when idle |
| async_present | input | 1 | Asynchronous kernel clock exists |
| async_rate_hz | input | RATE_W | Asynchronous clock rate in Hz |
| bus_present | input | 1 | Bus clock exists |
| bus_rate_hz | input | RATE_W | Bus clock rate in Hz |
| ctrl_in | input | CTRL_W | Current common control word |
| done | output | 1 | One-cycle end-of-search strobe |
| error | output | 1 | Last search failed |
| mode | output | 2 | Chosen clock mode |
| presc | output | 4 | Chosen prescaler code |
| ana_rate_hz | output | RATE_W | Resulting analog clock rate |
| boost | output | 1 | Analog rate above boost threshold |
| ctrl_out | output | CTRL_W | Control word with fields inserted |

## Verification
The asynchronous clock is swept through rates sitting one count below and exactly on each divisor's boundary. This tells apart an exact pick of the first fitting entry from an off-by-one in the fit test or in the table order. The last boundary also forces the fallback to the bus table, once with a valid bus rate and once with a zero one. The bus rate is swept the same way, both with an unusable asynchronous clock present and with it absent, which distinguishes the two scan-start latencies. Separate runs cover the missing-bus and zero-rate errors, and a start pulse plus input changes injected during a scan must leave the result untouched.

// File: rtl/adc_clk_pkg.sv
package adc_clk_pkg;

    localparam int unsigned NUM_ASYNC   = 12;
    localparam int unsigned NUM_SYNC    = 3;
    localparam int unsigned NUM_ENTRIES = NUM_ASYNC + NUM_SYNC;
    localparam int unsigned IDX_W       = $clog2(NUM_ENTRIES);
    localparam int unsigned DIV_W       = 9;
    localparam int unsigned MODE_W      = 2;
    localparam int unsigned PRESC_W     = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREP,
        ST_SCAN_ASYNC,
        ST_SCAN_BUS,
        ST_DONE_OK,
        ST_DONE_ERR
    } sel_state_t;

    typedef struct packed {
        logic [MODE_W-1:0]  mode;
        logic [PRESC_W-1:0] presc;
        logic [DIV_W-1:0]   div;
    } clk_entry_t;

    // Divisor of table position k: asynchronous entries first, then bus entries.
    function automatic int unsigned div_of(input int unsigned k);
        if (k == 0)               return 1;
        else if (k <= 6)          return 2 * k;
        else if (k < NUM_ASYNC)   return 16 << (k - 7);
        else if (k < NUM_ENTRIES) return 1 << (k - NUM_ASYNC);
        else                      return 1;
    endfunction

    function automatic int unsigned mode_of(input int unsigned k);
        if (k < NUM_ASYNC)        return 0;
        else if (k < NUM_ENTRIES) return k - NUM_ASYNC + 1;
        else                      return 0;
    endfunction

    function automatic int unsigned presc_of(input int unsigned k);
        if (k < NUM_ASYNC) return k;
        else               return 0;
    endfunction

endpackage

// File: rtl/adc_clk_entry_lookup.sv
module adc_clk_entry_lookup
    import adc_clk_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    output clk_entry_t       entry,
    output logic             last_async,
    output logic             last_sync
);

    always_comb begin
        entry.mode  = MODE_W'(mode_of(32'(idx)));
        entry.presc = PRESC_W'(presc_of(32'(idx)));
        entry.div   = DIV_W'(div_of(32'(idx)));
        last_async  = (32'(idx) == NUM_ASYNC - 1);
        last_sync   = (32'(idx) == NUM_ENTRIES - 1);
    end

endmodule

// File: rtl/adc_clk_fit_check.sv
module adc_clk_fit_check
    import adc_clk_pkg::*;
#(
    parameter int unsigned RATE_W = 32,
    parameter int unsigned MAX_HZ = 36_000_000
) (
    input  logic [RATE_W-1:0] rate,
    input  logic [DIV_W-1:0]  div,
    output logic              fit
);

    localparam int unsigned PW = RATE_W + DIV_W + 1;
    localparam logic [PW-1:0] LIM_BASE = PW'(MAX_HZ) + PW'(1);

    logic [PW-1:0] limit;

    // rate/div <= MAX  <=>  rate < (MAX+1)*div  (no divider needed)
    always_comb begin
        limit = LIM_BASE * PW'(div);
        fit   = (PW'(rate) < limit);
    end

endmodule

// File: rtl/adc_clk_rate_divide.sv
module adc_clk_rate_divide
    import adc_clk_pkg::*;
#(
    parameter int unsigned RATE_W = 32
) (
    input  logic [RATE_W-1:0] rate,
    input  logic [IDX_W-1:0]  idx,
    output logic [RATE_W-1:0] quot
);

    logic [RATE_W-1:0] quot_all [NUM_ENTRIES];

    // One constant divider per table position; the index picks one.
    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_div
        localparam int unsigned D = div_of(g);
        assign quot_all[g] = rate / RATE_W'(D);
    end

    always_comb begin
        if (32'(idx) < NUM_ENTRIES) quot = quot_all[idx];
        else                        quot = '0;
    end

endmodule

// File: rtl/adc_clk_sel.sv
module adc_clk_sel
    import adc_clk_pkg::*;
#(
    parameter int unsigned RATE_W    = 32,
    parameter int unsigned CTRL_W    = 32,
    parameter int unsigned MAX_HZ    = 36_000_000,
    parameter int unsigned BOOST_HZ  = 20_000_000,
    parameter int unsigned MODE_LSB  = 16,
    parameter int unsigned PRESC_LSB = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              async_present,
    input  logic [RATE_W-1:0] async_rate_hz,
    input  logic              bus_present,
    input  logic [RATE_W-1:0] bus_rate_hz,
    input  logic [CTRL_W-1:0] ctrl_in,
    output logic              done,
    output logic              error,
    output logic [1:0]        mode,
    output logic [3:0]        presc,
    output logic [RATE_W-1:0] ana_rate_hz,
    output logic              boost,
    output logic [CTRL_W-1:0] ctrl_out
);

    localparam logic [IDX_W-1:0] FIRST_ASYNC = '0;
    localparam logic [IDX_W-1:0] FIRST_SYNC  = IDX_W'(NUM_ASYNC);

    sel_state_t        state_q, state_d;
    logic [IDX_W-1:0]  idx_q, idx_d;
    logic              async_pres_q, bus_pres_q;
    logic [RATE_W-1:0] async_rate_q, bus_rate_q;
    logic [CTRL_W-1:0] ctrl_q;

    logic [RATE_W-1:0] cur_rate;
    clk_entry_t        entry;
    logic              last_async, last_sync, fit;
    logic [RATE_W-1:0] quot;
    logic [CTRL_W-1:0] ctrl_merged;

    logic              res_err, res_boost;
    logic [1:0]        res_mode;
    logic [3:0]        res_presc;
    logic [RATE_W-1:0] res_rate;
    logic [CTRL_W-1:0] res_ctrl;

    assign cur_rate = (state_q == ST_SCAN_BUS) ? bus_rate_q : async_rate_q;

    adc_clk_entry_lookup u_lookup (
        .idx        (idx_q),
        .entry      (entry),
        .last_async (last_async),
        .last_sync  (last_sync)
    );

    adc_clk_fit_check #(
        .RATE_W (RATE_W),
        .MAX_HZ (MAX_HZ)
    ) u_fit (
        .rate (cur_rate),
        .div  (entry.div),
        .fit  (fit)
    );

    adc_clk_rate_divide #(
        .RATE_W (RATE_W)
    ) u_div (
        .rate (cur_rate),
        .idx  (idx_q),
        .quot (quot)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = ST_PREP;
            end
            ST_PREP: begin
                if (!bus_pres_q) begin
                    state_d = ST_DONE_ERR;
                end else if (async_pres_q) begin
                    if (async_rate_q == '0) begin
                        state_d = ST_DONE_ERR;
                    end else begin
                        state_d = ST_SCAN_ASYNC;
                        idx_d   = FIRST_ASYNC;
                    end
                end else if (bus_rate_q == '0) begin
                    state_d = ST_DONE_ERR;
                end else begin
                    state_d = ST_SCAN_BUS;
                    idx_d   = FIRST_SYNC;
                end
            end
            ST_SCAN_ASYNC: begin
                if (fit) begin
                    state_d = ST_DONE_OK;
                end else if (last_async) begin
                    if (bus_rate_q == '0) begin
                        state_d = ST_DONE_ERR;
                    end else begin
                        state_d = ST_SCAN_BUS;
                        idx_d   = FIRST_SYNC;
                    end
                end else begin
                    idx_d = IDX_W'(idx_q + 1'b1);
                end
            end
            ST_SCAN_BUS: begin
                if (fit)            state_d = ST_DONE_OK;
                else if (last_sync) state_d = ST_DONE_ERR;
                else                idx_d   = IDX_W'(idx_q + 1'b1);
            end
            ST_DONE_OK:  state_d = ST_IDLE;
            ST_DONE_ERR: state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // State register and input capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            idx_q        <= '0;
            async_pres_q <= 1'b0;
            bus_pres_q   <= 1'b0;
            async_rate_q <= '0;
            bus_rate_q   <= '0;
            ctrl_q       <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            if (state_q == ST_IDLE && start) begin
                async_pres_q <= async_present;
                bus_pres_q   <= bus_present;
                async_rate_q <= async_rate_hz;
                bus_rate_q   <= bus_rate_hz;
                ctrl_q       <= ctrl_in;
            end
        end
    end

    always_comb begin
        ctrl_merged = ctrl_q;
        ctrl_merged[MODE_LSB +: 2]  = entry.mode;
        ctrl_merged[PRESC_LSB +: 4] = entry.presc;
    end

    // Result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_err   <= 1'b0;
            res_boost <= 1'b0;
            res_mode  <= '0;
            res_presc <= '0;
            res_rate  <= '0;
            res_ctrl  <= '0;
        end else if (state_d == ST_DONE_OK) begin
            res_err   <= 1'b0;
            res_boost <= (64'(quot) > 64'(BOOST_HZ));
            res_mode  <= entry.mode;
            res_presc <= entry.presc;
            res_rate  <= quot;
            res_ctrl  <= ctrl_merged;
        end else if (state_d == ST_DONE_ERR) begin
            res_err   <= 1'b1;
            res_boost <= 1'b0;
            res_mode  <= '0;
            res_presc <= '0;
            res_rate  <= '0;
            res_ctrl  <= ctrl_q;
        end
    end

    assign done        = (state_q == ST_DONE_OK) || (state_q == ST_DONE_ERR);
    assign error       = res_err;
    assign mode        = res_mode;
    assign presc       = res_presc;
    assign ana_rate_hz = res_rate;
    assign boost       = res_boost;
    assign ctrl_out    = res_ctrl;

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && error) |-> (ana_rate_hz == '0 && mode == '0 && presc == '0));

    // R2
    rate_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !error) |-> (64'(ana_rate_hz) <= 64'(MAX_HZ)));

    // R7
    boost_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !error) |-> (boost == (64'(ana_rate_hz) > 64'(BOOST_HZ))));

    // R11
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> (state_q != ST_PREP));

    // R3
    bus_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN_BUS) |-> (idx_q >= FIRST_SYNC && 32'(idx_q) < NUM_ENTRIES));

    // R8
    ctrl_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !error) |-> (ctrl_out[MODE_LSB +: 2] == mode && ctrl_out[PRESC_LSB +: 4] == presc));

endmodule

// File: tb/test_adc_clk_sel.sv
module test_adc_clk_sel;

    localparam time         CLK_PERIOD = 10ns;
    localparam int unsigned M_HZ       = 1_000_000;
    localparam int unsigned B_HZ       = 500_000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        async_present = 1'b0;
    logic [31:0] async_rate_hz = '0;
    logic        bus_present = 1'b0;
    logic [31:0] bus_rate_hz = '0;
    logic [31:0] ctrl_in = '0;
    logic        done, error, boost;
    logic [1:0]  mode;
    logic [3:0]  presc;
    logic [31:0] ana_rate_hz, ctrl_out;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    int unsigned adiv [12] = '{1, 2, 4, 6, 8, 10, 12, 16, 32, 64, 128, 256};
    int unsigned sdiv [3]  = '{1, 2, 4};

    adc_clk_sel #(
        .MAX_HZ   (M_HZ),
        .BOOST_HZ (B_HZ)
    ) i_adc_clk_sel (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .async_present (async_present),
        .async_rate_hz (async_rate_hz),
        .bus_present   (bus_present),
        .bus_rate_hz   (bus_rate_hz),
        .ctrl_in       (ctrl_in),
        .done          (done),
        .error         (error),
        .mode          (mode),
        .presc         (presc),
        .ana_rate_hz   (ana_rate_hz),
        .boost         (boost),
        .ctrl_out      (ctrl_out)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run hung, act=%0d exp<150000", cyc);
            summary();
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: act=%0d (0x%0h) exp=%0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    // One search; expected values from the requirements.
    task automatic run(input bit ap, input longint unsigned ar, input bit bp,
                       input longint unsigned br, input logic [31:0] cin, input bit poke);
        bit                e_err = 1'b0;
        bit                found = 1'b0;
        int                e_lat = 0;
        int unsigned       e_mode = 0, e_presc = 0;
        longint unsigned   e_rate = 0;
        logic [31:0]       e_ctrl;
        int                cycles;
        int                base;

        if (!bp) begin
            e_err = 1'b1; e_lat = 1;
        end else if (ap && ar == 0) begin
            e_err = 1'b1; e_lat = 1;
        end else begin
            if (ap) begin
                for (int i = 0; i < 12; i++) begin
                    if (!found && (ar / adiv[i]) <= M_HZ) begin
                        found = 1'b1; e_mode = 0; e_presc = i;
                        e_rate = ar / adiv[i]; e_lat = 2 + i;
                    end
                end
            end
            if (!found) begin
                base = ap ? 14 : 2;
                if (br == 0) begin
                    e_err = 1'b1; e_lat = ap ? 13 : 1;
                end else begin
                    for (int j = 0; j < 3; j++) begin
                        if (!found && (br / sdiv[j]) <= M_HZ) begin
                            found = 1'b1; e_mode = j + 1; e_presc = 0;
                            e_rate = br / sdiv[j]; e_lat = base + j;
                        end
                    end
                    if (!found) begin
                        e_err = 1'b1; e_lat = base + 2;
                    end
                end
            end
        end
        e_ctrl = cin;
        if (!e_err) begin
            e_ctrl[17:16] = 2'(e_mode);
            e_ctrl[21:18] = 4'(e_presc);
        end

        @(negedge clk);
        async_present = ap; async_rate_hz = 32'(ar);
        bus_present = bp;   bus_rate_hz = 32'(br);
        ctrl_in = cin;      start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cycles = 0;
        if (poke) begin
            // R11 R12: start again and disturb inputs during the search
            start = 1'b1;
            async_rate_hz = 32'd5; bus_rate_hz = 32'd7;
            async_present = ~ap; ctrl_in = ~cin;
        end
        while (!done && cycles < 40) begin
            @(negedge clk);
            cycles++;
            if (cycles == 1) start = 1'b0;
        end
        chk(cycles == e_lat, "R9 latency", cycles, e_lat);
        chk(error == e_err, "R5 error", error, e_err);
        chk(mode == 2'(e_mode), "R2 R3 mode", mode, e_mode);
        chk(presc == 4'(e_presc), "R2 presc", presc, e_presc);
        chk(ana_rate_hz == 32'(e_rate), "R6 rate", ana_rate_hz, e_rate);
        chk(boost == (!e_err && e_rate > B_HZ), "R7 boost", boost, (!e_err && e_rate > B_HZ));
        chk(ctrl_out == e_ctrl, "R8 ctrl_out", ctrl_out, e_ctrl);
        @(negedge clk);
        chk(done == 1'b0, "R10 done width", done, 0);
        if (poke) chk(!done, "R11 no second search", done, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(done == 0 && error == 0, "R1 flags", {done, error}, 0);
        chk(mode == 0 && presc == 0 && boost == 0, "R1 fields", {mode, presc, boost}, 0);
        chk(ana_rate_hz == 0 && ctrl_out == 0, "R1 data", ana_rate_hz | ctrl_out, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 R4: async boundaries, bus rate valid or zero (zero ignored on fit)
        for (int i = 0; i < 12; i++) begin
            for (int k = 0; k < 2; k++) begin
                for (int z = 0; z < 2; z++) begin
                    run(1'b1, longint'(adiv[i]) * M_HZ + adiv[i] - 1 + k, 1'b1,
                        z ? 0 : 3_000_003, 32'hA5A5_5A5A ^ (i << 4), 1'b0);
                end
            end
        end

        // R3 R4: bus boundaries with unusable async clock present, then absent
        for (int p = 0; p < 2; p++) begin
            for (int j = 0; j < 3; j++) begin
                for (int k = 0; k < 2; k++) begin
                    run(p == 0, 300_000_000, 1'b1,
                        longint'(sdiv[j]) * M_HZ + sdiv[j] - 1 + k, 32'hFFFF_FFFF, 1'b0);
                end
            end
        end

        // R5 error sources
        run(1'b1, 5_000_000, 1'b0, 1_000_000, 32'h1234_5678, 1'b0);
        run(1'b1, 0, 1'b1, 1_000_000, 32'h0F0F_0F0F, 1'b0);
        run(1'b0, 2_000_000, 1'b1, 0, 32'h0, 1'b0);
        run(1'b1, 300_000_000, 1'b1, 0, 32'hDEAD_BEEF, 1'b0);

        // R11 R12: busy start and input changes have no effect
        run(1'b1, 9_000_000, 1'b1, 1_000_000, 32'h0003_0000, 1'b1);
        run(1'b0, 3_500_000, 1'b1, 3_500_000, 32'h003C_0000, 1'b1);

        summary();
    end

endmodule